// File: doc/BRIEF.md
# Page-Walk Request Merge Filter

This block sits between several first-level TLB miss channels and one shared page-table walker port. On every cycle each channel may present a miss, identified by its virtual page number (VPN). The block compares each miss with the misses on the other channels in the same cycle, with the VPNs it already holds, and with any walk response arriving in that cycle. Only a VPN that is new on all three counts takes one of the tracking entries. As a result, each distinct page is walked once, however many channels miss on it.

Held entries go to the walker one at a time over a valid-ready handshake, oldest unsent entry first. When the walker answers, the block forwards the answer to the TLB side one cycle later. At the same clock edge it frees every entry holding that VPN. If a new miss cannot get an entry because all are in use, the block raises a not-accepted flag for that channel in the same cycle, so the TLB replays the miss. If a miss matches a response arriving in the same cycle, the block flags it as served.

The walk request is driven by a two-state issue machine. `IS_IDLE` waits for an unsent entry. On the cycle it finds one (transition *pick*), it latches the entry's VPN and index and moves to `IS_OFFER`. `IS_OFFER` holds the walk request valid with a stable VPN until the walker accepts it. On acceptance (transition *accept*) the entry is marked sent and the machine returns to `IS_IDLE`. Without acceptance (transition *stall*) it stays in `IS_OFFER`. While an entry is on offer, its slot is not handed to a new miss, even if a response frees it.

Top module: `ptw_merge_filter`

## Requirements
- R1: After reset, no walk request is valid, no response is forwarded, no channel flag is raised, and all NENT entries are free.
- R2: A valid miss whose VPN is new takes a free entry. Two cycles after the miss cycle, `walk_valid` is high with that VPN. While `walk_ready` is low, `walk_valid` stays high and `walk_vpn` stays unchanged.
- R3: When several channels present the same new VPN in one cycle, exactly one entry is taken and exactly one walk is issued for that VPN.
- R4: A miss whose VPN equals a held entry's VPN takes no entry, issues no walk, and is not flagged as not accepted.
- R5: Unsent entries are offered oldest first. Among misses allocated in the same cycle, the lower-numbered channel counts as older.
- R6: At most NENT distinct VPNs are held. A new VPN that finds no free entry raises `req_nack` for its channel in the same cycle. A later channel carrying the same VPN as an earlier not-accepted channel is also flagged. Once a response frees an entry that is not on offer, a new VPN is accepted again.
- R7: A response presented with `rsp_valid` appears one cycle later on the `up_*` outputs, with the same VPN, PPN, permission, level and fault values. At that same edge, every entry holding the VPN is freed, so a later miss on the VPN issues a new walk. `up_valid` is low in the cycle after a cycle without a response.
- R8: A miss whose VPN equals the VPN of a response valid in the same cycle raises `req_done` for its channel, is not flagged as not accepted, and issues no walk.
- R9: `req_nack` and `req_done` are raised only for channels with `req_valid` high, and never both for the same channel.
- R10: After the walker accepts an entry, `walk_valid` drops in the next cycle, and that entry is never offered again while it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCH | Miss present, one bit per channel |
| req_vpn | input | NCH*VPN_W | Miss VPNs; channel c occupies bits [c*VPN_W +: VPN_W] |
| req_nack | output | NCH | Miss not accepted this cycle; the TLB must replay it |
| req_done | output | NCH | Miss served by the response valid this cycle |
| walk_valid | output | 1 | Walk request valid |
| walk_ready | input | 1 | Walker accepts the request |
| walk_vpn | output | VPN_W | VPN to walk |
| rsp_valid | input | 1 | Walker response valid |
| rsp_vpn | input | VPN_W | Response VPN |
| rsp_ppn | input | PPN_W | Response physical page number |
| rsp_perm | input | PERM_W | Response permission bits |
| rsp_level | input | LVL_W | Response page-table level |
| rsp_fault | input | 1 | Response carries a fault |
| up_valid | output | 1 | Forwarded response valid |
| up_vpn | output | VPN_W | Forwarded VPN |
| up_ppn | output | PPN_W | Forwarded physical page number |
| up_perm | output | PERM_W | Forwarded permission bits |
| up_level | output | LVL_W | Forwarded level |
| up_fault | output | 1 | Forwarded fault flag |

## Verification
The hardest state to reach from the ports is a full table, in which the entry on offer is stalled while misses keep arriving. This matters because a not-accepted leader channel must drag its same-VPN follower along, and freeing a non-offered entry must reopen exactly one slot. The bench gets there by filling all eight entries over four two-channel cycles with `walk_ready` held low. It then probes with a repeated new VPN, a mixed held/new pair, and a response to an entry that is not on offer. Besides this, the bench sweeps every ordered pair from a small VPN set over both channels to cover merge and ordering. It also lines up a response and a same-VPN miss in one cycle.

// File: rtl/ptwf_pkg.sv
package ptwf_pkg;

    typedef enum logic [0:0] {
        IS_IDLE  = 1'b0,
        IS_OFFER = 1'b1
    } issue_state_e;

endpackage

// File: rtl/ptwf_dedup.sv
// Per-channel classification of incoming misses and slot assignment.
module ptwf_dedup #(
    parameter int NCH   = 2,
    parameter int NENT  = 8,
    parameter int VPN_W = 27,
    parameter int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]             req_valid,
    input  logic [NCH*VPN_W-1:0]       req_vpn,
    input  logic [NENT-1:0]            ent_valid,
    input  logic [NENT-1:0][VPN_W-1:0] ent_vpn,
    input  logic [NENT-1:0]            free_mask,
    input  logic                       rsp_valid,
    input  logic [VPN_W-1:0]           rsp_vpn,
    output logic [NENT-1:0]            alloc_en,
    output logic [NENT-1:0][VPN_W-1:0] alloc_vpn,
    output logic [NENT-1:0][CH_W-1:0]  alloc_ch,
    output logic [NCH-1:0]             req_nack,
    output logic [NCH-1:0]             req_done
);

    logic [NENT-1:0]  avail;
    logic [VPN_W-1:0] cur_vpn;
    logic             hit_rsp;
    logic             hit_held;
    logic             lead_found;
    logic             lead_nack;
    logic             got_slot;

    always_comb begin
        avail      = free_mask;
        alloc_en   = '0;
        alloc_vpn  = '0;
        alloc_ch   = '0;
        req_nack   = '0;
        req_done   = '0;
        cur_vpn    = '0;
        hit_rsp    = 1'b0;
        hit_held   = 1'b0;
        lead_found = 1'b0;
        lead_nack  = 1'b0;
        got_slot   = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            cur_vpn  = req_vpn[c*VPN_W +: VPN_W];
            hit_rsp  = rsp_valid && (rsp_vpn == cur_vpn);
            hit_held = 1'b0;
            for (int i = 0; i < NENT; i++) begin
                if (ent_valid[i] && (ent_vpn[i] == cur_vpn)) begin
                    hit_held = 1'b1;
                end
            end
            lead_found = 1'b0;
            lead_nack  = 1'b0;
            for (int p = 0; p < NCH; p++) begin
                if ((p < c) && !lead_found && req_valid[p]
                    && (req_vpn[p*VPN_W +: VPN_W] == cur_vpn)) begin
                    lead_found = 1'b1;
                    lead_nack  = req_nack[p];
                end
            end
            got_slot = 1'b0;
            if (req_valid[c]) begin
                if (hit_rsp) begin
                    req_done[c] = 1'b1;
                end else if (hit_held) begin
                    // merged into an outstanding entry
                    req_done[c] = 1'b0;
                end else if (lead_found) begin
                    req_nack[c] = lead_nack;
                end else begin
                    for (int k = 0; k < NENT; k++) begin
                        if (!got_slot && avail[k]) begin
                            got_slot     = 1'b1;
                            avail[k]     = 1'b0;
                            alloc_en[k]  = 1'b1;
                            alloc_vpn[k] = cur_vpn;
                            alloc_ch[k]  = CH_W'(c);
                        end
                    end
                    if (!got_slot) begin
                        req_nack[c] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ptwf_age.sv
// Relative-age matrix over the entries; picks the oldest candidate.
module ptwf_age #(
    parameter int NENT  = 8,
    parameter int CH_W  = 1,
    parameter int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NENT-1:0]           alloc_en,
    input  logic [NENT-1:0][CH_W-1:0] alloc_ch,
    input  logic [NENT-1:0]           ent_valid,
    input  logic [NENT-1:0]           cand,
    output logic                      pick_valid,
    output logic [IDX_W-1:0]          pick_idx
);

    // older_q[j][i] set: entry j was allocated before entry i
    logic [NENT-1:0][NENT-1:0] older_q;
    logic [NENT-1:0][NENT-1:0] older_d;
    logic                      blocked;

    always_comb begin
        older_d = older_q;
        for (int k = 0; k < NENT; k++) begin
            if (alloc_en[k]) begin
                for (int j = 0; j < NENT; j++) begin
                    if (j != k) begin
                        older_d[j][k] = ent_valid[j]
                                        || (alloc_en[j] && (alloc_ch[j] < alloc_ch[k]));
                        older_d[k][j] = alloc_en[j] && (alloc_ch[j] > alloc_ch[k]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            older_q <= older_d;
        end
    end

    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        blocked    = 1'b0;
        for (int i = 0; i < NENT; i++) begin
            blocked = 1'b0;
            for (int j = 0; j < NENT; j++) begin
                if ((j != i) && cand[j] && older_q[j][i]) begin
                    blocked = 1'b1;
                end
            end
            if (!pick_valid && cand[i] && !blocked) begin
                pick_valid = 1'b1;
                pick_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ptwf_issue.sv
// Two-state machine presenting one entry at a time to the walker.
module ptwf_issue
    import ptwf_pkg::*;
#(
    parameter int NENT  = 8,
    parameter int VPN_W = 27,
    parameter int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pick_valid,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic [VPN_W-1:0] pick_vpn,
    input  logic             walk_ready,
    output logic             walk_valid,
    output logic [VPN_W-1:0] walk_vpn,
    output logic             offer_busy,
    output logic [IDX_W-1:0] offer_idx,
    output logic             sent_pulse
);

    issue_state_e     state_q;
    issue_state_e     state_d;
    logic [VPN_W-1:0] vpn_q;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IS_IDLE:  if (pick_valid) state_d = IS_OFFER;
            IS_OFFER: if (walk_ready) state_d = IS_IDLE;
            default:  state_d = IS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IS_IDLE;
            vpn_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == IS_IDLE) && pick_valid) begin
                vpn_q <= pick_vpn;
                idx_q <= pick_idx;
            end
        end
    end

    always_comb begin
        walk_valid = 1'b0;
        offer_busy = 1'b0;
        sent_pulse = 1'b0;
        unique case (state_q)
            IS_IDLE: begin
                walk_valid = 1'b0;
            end
            IS_OFFER: begin
                walk_valid = 1'b1;
                offer_busy = 1'b1;
                sent_pulse = walk_ready;
            end
            default: begin
                walk_valid = 1'b0;
            end
        endcase
        walk_vpn  = vpn_q;
        offer_idx = idx_q;
    end

endmodule

// File: rtl/ptw_merge_filter.sv
module ptw_merge_filter #(
    parameter int NCH    = 2,
    parameter int NENT   = 8,
    parameter int VPN_W  = 27,
    parameter int PPN_W  = 24,
    parameter int PERM_W = 8,
    parameter int LVL_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        req_valid,
    input  logic [NCH*VPN_W-1:0]  req_vpn,
    output logic [NCH-1:0]        req_nack,
    output logic [NCH-1:0]        req_done,
    output logic                  walk_valid,
    input  logic                  walk_ready,
    output logic [VPN_W-1:0]      walk_vpn,
    input  logic                  rsp_valid,
    input  logic [VPN_W-1:0]      rsp_vpn,
    input  logic [PPN_W-1:0]      rsp_ppn,
    input  logic [PERM_W-1:0]     rsp_perm,
    input  logic [LVL_W-1:0]      rsp_level,
    input  logic                  rsp_fault,
    output logic                  up_valid,
    output logic [VPN_W-1:0]      up_vpn,
    output logic [PPN_W-1:0]      up_ppn,
    output logic [PERM_W-1:0]     up_perm,
    output logic [LVL_W-1:0]      up_level,
    output logic                  up_fault
);

    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;

    logic [NENT-1:0]            ent_valid;
    logic [NENT-1:0]            ent_sent;
    logic [NENT-1:0][VPN_W-1:0] ent_vpn;

    logic [NENT-1:0]            rsp_hit;
    logic [NENT-1:0]            offer_mask;
    logic [NENT-1:0]            free_mask;
    logic [NENT-1:0]            cand;
    logic [NENT-1:0]            alloc_en;
    logic [NENT-1:0][VPN_W-1:0] alloc_vpn;
    logic [NENT-1:0][CH_W-1:0]  alloc_ch;

    logic                       pick_valid;
    logic [IDX_W-1:0]           pick_idx;
    logic                       offer_busy;
    logic [IDX_W-1:0]           offer_idx;
    logic                       sent_pulse;

    for (genvar g = 0; g < NENT; g++) begin : g_ent_comb
        assign rsp_hit[g]    = rsp_valid && ent_valid[g] && (ent_vpn[g] == rsp_vpn);
        assign offer_mask[g] = offer_busy && (offer_idx == IDX_W'(g));
        assign free_mask[g]  = !ent_valid[g] && !offer_mask[g];
        assign cand[g]       = ent_valid[g] && !ent_sent[g] && !rsp_hit[g];
    end

    ptwf_dedup #(
        .NCH   (NCH),
        .NENT  (NENT),
        .VPN_W (VPN_W),
        .CH_W  (CH_W)
    ) u_dedup (
        .req_valid (req_valid),
        .req_vpn   (req_vpn),
        .ent_valid (ent_valid),
        .ent_vpn   (ent_vpn),
        .free_mask (free_mask),
        .rsp_valid (rsp_valid),
        .rsp_vpn   (rsp_vpn),
        .alloc_en  (alloc_en),
        .alloc_vpn (alloc_vpn),
        .alloc_ch  (alloc_ch),
        .req_nack  (req_nack),
        .req_done  (req_done)
    );

    ptwf_age #(
        .NENT  (NENT),
        .CH_W  (CH_W),
        .IDX_W (IDX_W)
    ) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .alloc_ch   (alloc_ch),
        .ent_valid  (ent_valid),
        .cand       (cand),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    ptwf_issue #(
        .NENT  (NENT),
        .VPN_W (VPN_W),
        .IDX_W (IDX_W)
    ) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .pick_vpn   (ent_vpn[pick_idx]),
        .walk_ready (walk_ready),
        .walk_valid (walk_valid),
        .walk_vpn   (walk_vpn),
        .offer_busy (offer_busy),
        .offer_idx  (offer_idx),
        .sent_pulse (sent_pulse)
    );

    for (genvar g = 0; g < NENT; g++) begin : g_ent_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[g] <= 1'b0;
                ent_sent[g]  <= 1'b0;
                ent_vpn[g]   <= '0;
            end else if (rsp_hit[g]) begin
                ent_valid[g] <= 1'b0;
                ent_sent[g]  <= 1'b0;
            end else if (alloc_en[g]) begin
                ent_valid[g] <= 1'b1;
                ent_sent[g]  <= 1'b0;
                ent_vpn[g]   <= alloc_vpn[g];
            end else if (sent_pulse && (offer_idx == IDX_W'(g))) begin
                ent_sent[g]  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_valid <= 1'b0;
            up_vpn   <= '0;
            up_ppn   <= '0;
            up_perm  <= '0;
            up_level <= '0;
            up_fault <= 1'b0;
        end else begin
            up_valid <= rsp_valid;
            if (rsp_valid) begin
                up_vpn   <= rsp_vpn;
                up_ppn   <= rsp_ppn;
                up_perm  <= rsp_perm;
                up_level <= rsp_level;
                up_fault <= rsp_fault;
            end
        end
    end

endmodule

// File: rtl/ptwf_checker.sv
module ptwf_checker #(
    parameter int NCH   = 2,
    parameter int VPN_W = 27
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       req_valid,
    input logic [NCH*VPN_W-1:0] req_vpn,
    input logic [NCH-1:0]       req_nack,
    input logic [NCH-1:0]       req_done,
    input logic                 walk_valid,
    input logic                 walk_ready,
    input logic [VPN_W-1:0]     walk_vpn,
    input logic                 rsp_valid,
    input logic [VPN_W-1:0]     rsp_vpn,
    input logic                 up_valid,
    input logic [VPN_W-1:0]     up_vpn
);

    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        walk_valid && !walk_ready |=> walk_valid && $stable(walk_vpn)); // R2

    AST_UP_FOLLOWS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> up_valid && (up_vpn == $past(rsp_vpn))); // R7

    AST_UP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> !up_valid); // R7

    AST_DONE_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_done) |-> rsp_valid); // R8

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_nack & req_done) == '0) && (((req_nack | req_done) & ~req_valid) == '0)); // R9

    AST_SENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        walk_valid && walk_ready |=> !walk_valid); // R10

    for (genvar c = 1; c < NCH; c++) begin : g_follow
        AST_FOLLOW_NACK: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[0] && req_valid[c]
            && (req_vpn[c*VPN_W +: VPN_W] == req_vpn[VPN_W-1:0])
            |-> (req_nack[c] == req_nack[0])); // R6
    end

endmodule

bind ptw_merge_filter ptwf_checker #(
    .NCH   (NCH),
    .VPN_W (VPN_W)
) u_ptwf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vpn    (req_vpn),
    .req_nack   (req_nack),
    .req_done   (req_done),
    .walk_valid (walk_valid),
    .walk_ready (walk_ready),
    .walk_vpn   (walk_vpn),
    .rsp_valid  (rsp_valid),
    .rsp_vpn    (rsp_vpn),
    .up_valid   (up_valid),
    .up_vpn     (up_vpn)
);

// File: tb/tb_ptw_merge_filter.sv
`timescale 1ns/1ps
module tb_ptw_merge_filter;

    localparam int NCH = 2, NENT = 8, VPN_W = 27, PPN_W = 24, PERM_W = 8, LVL_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] req_valid = '0;
    logic [NCH*VPN_W-1:0] req_vpn = '0;
    logic [NCH-1:0] req_nack, req_done;
    logic walk_valid, walk_ready = 1'b0;
    logic [VPN_W-1:0] walk_vpn;
    logic rsp_valid = 1'b0;
    logic [VPN_W-1:0] rsp_vpn = '0;
    logic [PPN_W-1:0] rsp_ppn = '0;
    logic [PERM_W-1:0] rsp_perm = '0;
    logic [LVL_W-1:0] rsp_level = '0;
    logic rsp_fault = 1'b0;
    logic up_valid, up_fault;
    logic [VPN_W-1:0] up_vpn;
    logic [PPN_W-1:0] up_ppn;
    logic [PERM_W-1:0] up_perm;
    logic [LVL_W-1:0] up_level;

    always #2 clk = ~clk;

    ptw_merge_filter #(.NCH(NCH), .NENT(NENT), .VPN_W(VPN_W), .PPN_W(PPN_W),
                       .PERM_W(PERM_W), .LVL_W(LVL_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
        .req_nack(req_nack), .req_done(req_done), .walk_valid(walk_valid),
        .walk_ready(walk_ready), .walk_vpn(walk_vpn), .rsp_valid(rsp_valid),
        .rsp_vpn(rsp_vpn), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
        .rsp_level(rsp_level), .rsp_fault(rsp_fault), .up_valid(up_valid),
        .up_vpn(up_vpn), .up_ppn(up_ppn), .up_perm(up_perm),
        .up_level(up_level), .up_fault(up_fault));

    int n_tests = 0;
    int n_fail  = 0;
    bit reported = 1'b0;
    logic [NCH-1:0] s_nack, s_done;
    logic [VPN_W-1:0] got [0:15];
    int n_got;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    // At a falling edge: present one miss cycle, sample the flags, return at next falling edge.
    task automatic miss(input logic v0, input int a0, input logic v1, input int a1);
        req_valid = {v1, v0};
        req_vpn   = {VPN_W'(a1), VPN_W'(a0)};
        #1;
        s_nack = req_nack;
        s_done = req_done;
        @(negedge clk);
        req_valid = '0;
    endtask

    // Accept every offered walk during n cycles, recording VPNs.
    task automatic collect(input int n);
        n_got = 0;
        for (int i = 0; i < n; i++) begin
            walk_ready = 1'b0;
            if (walk_valid) begin
                if (n_got < 16) got[n_got] = walk_vpn;
                n_got++;
                walk_ready = 1'b1;
            end
            @(negedge clk);
        end
        walk_ready = 1'b0;
    endtask

    task automatic respond(input int v, input string req);
        rsp_valid = 1'b1;
        rsp_vpn   = VPN_W'(v);
        rsp_ppn   = PPN_W'(v + 100);
        rsp_perm  = PERM_W'(v ^ 8'h5a);
        rsp_level = LVL_W'(v);
        rsp_fault = v[0];
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(up_valid && (up_vpn == VPN_W'(v)), req, longint'(up_vpn), v);
        chk((up_ppn == PPN_W'(v + 100)) && (up_perm == PERM_W'(v ^ 8'h5a))
            && (up_level == LVL_W'(v)) && (up_fault == v[0]), req, longint'(up_ppn), v + 100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle after reset
        chk(!walk_valid && !up_valid && (req_nack == '0) && (req_done == '0), "R1",
            {walk_valid, up_valid}, 0);
        @(negedge clk);

        // R2 single new miss, offered two cycles later, held while stalled
        miss(1'b1, 5, 1'b0, 0);
        chk(s_nack == '0 && s_done == '0, "R2", s_nack, 0);
        chk(!walk_valid, "R2", walk_valid, 0);
        @(negedge clk);
        chk(walk_valid && walk_vpn == 5, "R2", walk_vpn, 5);
        @(negedge clk);
        @(negedge clk);
        chk(walk_valid && walk_vpn == 5, "R2", walk_vpn, 5);
        walk_ready = 1'b1;
        @(negedge clk);
        walk_ready = 1'b0;
        chk(!walk_valid, "R10", walk_valid, 0);
        collect(6);
        chk(n_got == 0, "R10", n_got, 0);

        // R4 duplicate of a held entry
        miss(1'b0, 0, 1'b1, 5);
        chk(s_nack == '0 && s_done == '0, "R4", s_nack, 0);
        collect(6);
        chk(n_got == 0, "R4", n_got, 0);

        // R7 response frees the entry, re-request walks again
        respond(5, "R7");
        miss(1'b1, 5, 1'b0, 0);
        collect(6);
        chk(n_got == 1 && got[0] == 5, "R7", n_got, 1);
        respond(5, "R7");

        // R3/R5 sweep of all channel pairs over a small VPN set
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                miss(1'b1, 16 + a, 1'b1, 16 + b);
                collect(10);
                if (a == b) begin
                    chk(n_got == 1 && got[0] == VPN_W'(16 + a), "R3", n_got, 1);
                    respond(16 + a, "R7");
                end else begin
                    chk(n_got == 2 && got[0] == VPN_W'(16 + a) && got[1] == VPN_W'(16 + b),
                        "R5", longint'(got[0]), 16 + a);
                    respond(16 + a, "R7");
                    respond(16 + b, "R7");
                end
            end
        end

        // R5 ordering across cycles: 40, then 42 (ch0) before 41 (ch1)
        miss(1'b1, 40, 1'b0, 0);
        miss(1'b1, 42, 1'b1, 41);
        collect(12);
        chk(n_got == 3 && got[0] == 40 && got[1] == 42 && got[2] == 41, "R5",
            longint'(got[1]), 42);
        respond(40, "R7");
        respond(41, "R7");
        respond(42, "R7");

        // R6 full table with the walker stalled
        for (int k = 0; k < 4; k++) begin
            miss(1'b1, 50 + 2 * k, 1'b1, 51 + 2 * k);
            chk(s_nack == '0, "R6", s_nack, 0);
        end
        miss(1'b1, 58, 1'b1, 58);
        chk(s_nack == 2'b11 && s_done == '0, "R6", s_nack, 3);
        miss(1'b1, 50, 1'b1, 59);
        chk(s_nack == 2'b10, "R6", s_nack, 2);
        respond(51, "R7");
        miss(1'b0, 0, 1'b1, 59);
        chk(s_nack == '0, "R6", s_nack, 0);
        collect(30);
        chk(n_got == 8 && got[0] == 50 && got[7] == 59, "R6", n_got, 8);
        respond(50, "R7");
        for (int k = 52; k < 58; k++) respond(k, "R7");
        respond(59, "R7");

        // R8 response and same-VPN miss in one cycle
        miss(1'b1, 60, 1'b0, 0);
        collect(6);
        chk(n_got == 1, "R8", n_got, 1);
        rsp_valid = 1'b1;
        rsp_vpn   = 60;
        rsp_ppn   = 160;
        rsp_perm  = PERM_W'(60 ^ 8'h5a);
        rsp_level = LVL_W'(60);
        rsp_fault = 1'b0;
        miss(1'b0, 0, 1'b1, 60);
        rsp_valid = 1'b0;
        chk(s_done == 2'b10 && s_nack == '0, "R8", s_done, 2);
        chk(s_done[0] == 1'b0 && s_nack[0] == 1'b0, "R9", s_done, 2);
        collect(6);
        chk(n_got == 0, "R8", n_got, 0);

        report();
        $finish;
    end

endmodule